// File: doc/BRIEF.md
# Four-Bit Accumulator Processor

This block is a small accumulator machine with a 4-bit data path and a 16-word program store inside it. A three-state controller runs each instruction in three clock cycles. In the first cycle it reads the word that the program counter points to into the instruction register and advances the counter. In the second cycle it latches the operation and operand from that register. In the third cycle it writes the result into the accumulator.

Each 7-bit instruction carries a 3-bit operation code and a 4-bit immediate value. There are eight operations: load, add, subtract, increment, decrement, AND, OR and XOR. The program is written through a simple write port while reset is held. After reset is released the processor runs freely. The accumulator, counter, instruction register, controller state and two flags are brought out for observation.

Top module: `acc4_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is: `pc_o`=0, `ir_o`=0, `acc_o`=0, `carry_o`=0, `state_o`=0.
- R2: Out of reset, `state_o` cycles 0 (fetch) -> 1 (decode) -> 2 (execute) -> 0, one step per clock, so every instruction takes exactly three cycles.
- R3: At the end of fetch, `ir_o` holds the program word at the old `pc_o` and `pc_o` has advanced by one, wrapping from 15 to 0.
- R4: The instruction word has the operation in bits [6:4] and the immediate in bits [3:0]. `acc_o` changes only at the end of execute.
- R5: Arithmetic is modulo 16. Operation 001 adds the immediate and sets `carry_o` to the carry out. Operation 010 subtracts the immediate and sets `carry_o` when a borrow occurs (acc < imm).
- R6: Operation 000 loads the immediate. Operations 101, 110 and 111 AND, OR and XOR the immediate into the accumulator. All four clear `carry_o`.
- R7: Operation 011 increments and operation 100 decrements the accumulator modulo 16. `carry_o` is set on 15->0 or 0->15. The immediate field has no effect on either.
- R8: `prog_we` writes `prog_data` at `prog_addr` only while `rst` is high. Writes made while the processor runs are ignored.
- R9: `zero_o` is high exactly when `acc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program writes |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_data | input | 7 | Program word to write |
| acc_o | output | 4 | Accumulator |
| pc_o | output | 4 | Program counter |
| ir_o | output | 7 | Instruction register |
| state_o | output | 2 | Controller state: 0 fetch, 1 decode, 2 execute |
| carry_o | output | 1 | Carry/borrow of the last execute |
| zero_o | output | 1 | Accumulator is zero |

## Verification
A controller that skips or repeats a state shows up within one cycle as a wrong `state_o`. It also shifts every later accumulator update off the three-cycle grid. A wrongly fetched or wrongly latched word appears at `ir_o` right after the fetch, and as a wrong `acc_o` two cycles later. A program word corrupted by a write made while running stays hidden until the counter wraps back to that address, so the bench runs longer than one pass through the store.

// File: rtl/acc4_cpu.sv
module acc4_cpu #(
  parameter int DW  = 4,
  parameter int AW  = 4,
  parameter int OPW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [OPW+DW-1:0]  prog_data,
  output logic [DW-1:0]      acc_o,
  output logic [AW-1:0]      pc_o,
  output logic [OPW+DW-1:0]  ir_o,
  output logic [1:0]         state_o,
  output logic               carry_o,
  output logic               zero_o
);
  localparam int IW    = OPW + DW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_FETCH = 2'd0, S_DECODE = 2'd1, S_EXEC = 2'd2} state_t;

  localparam logic [OPW-1:0] OP_LD  = 3'd0;
  localparam logic [OPW-1:0] OP_ADD = 3'd1;
  localparam logic [OPW-1:0] OP_SUB = 3'd2;
  localparam logic [OPW-1:0] OP_INC = 3'd3;
  localparam logic [OPW-1:0] OP_DEC = 3'd4;
  localparam logic [OPW-1:0] OP_AND = 3'd5;
  localparam logic [OPW-1:0] OP_OR  = 3'd6;
  localparam logic [OPW-1:0] OP_XOR = 3'd7;

  logic [IW-1:0]  store [DEPTH];
  state_t         state;
  logic [AW-1:0]  pc;
  logic [IW-1:0]  ir;
  logic [DW-1:0]  acc;
  logic           cy;
  logic [OPW-1:0] op_q;
  logic [DW-1:0]  imm_q;
  logic [DW:0]    res;

  always_ff @(posedge clk)
    if (rst && prog_we) store[prog_addr] <= prog_data;

  always_comb begin
    case (op_q)
      OP_LD:   res = {1'b0, imm_q};
      OP_ADD:  res = {1'b0, acc} + {1'b0, imm_q};
      OP_SUB:  res = {acc < imm_q, acc - imm_q};
      OP_INC:  res = {acc == '1, acc + DW'(1)};
      OP_DEC:  res = {acc == '0, acc - DW'(1)};
      OP_AND:  res = {1'b0, acc & imm_q};
      OP_OR:   res = {1'b0, acc | imm_q};
      default: res = {1'b0, acc ^ imm_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
      cy    <= 1'b0;
      op_q  <= '0;
      imm_q <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= store[pc];
          pc    <= pc + AW'(1);
          state <= S_DECODE;
        end
        S_DECODE: begin
          op_q  <= ir[IW-1:DW];
          imm_q <= ir[DW-1:0];
          state <= S_EXEC;
        end
        S_EXEC: begin
          acc   <= res[DW-1:0];
          cy    <= res[DW];
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign acc_o   = acc;
  assign pc_o    = pc;
  assign ir_o    = ir;
  assign state_o = state;
  assign carry_o = cy;
  assign zero_o  = (acc == '0);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && ir == '0 && acc == '0 && !cy && state == S_FETCH));

  p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);
  p_decode_next_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_DECODE |=> state == S_EXEC);
  p_exec_next_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_EXEC |=> state == S_FETCH);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> pc == $past(pc) + AW'(1));
  p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> ir == $past(store[pc]));
  p_ir_hold_r3: assert property (@(posedge clk) disable iff (rst)
    state != S_FETCH |=> $stable(ir));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    state != S_EXEC |=> $stable(acc));

  p_store_locked_r8: assert property (@(posedge clk)
    (!rst && prog_we) |=> store[$past(prog_addr)] == $past(store[prog_addr]));
endmodule

// File: tb/tb_acc4_cpu.sv
`timescale 1ns/1ps
module tb_acc4_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_we = 1'b0;
  logic [3:0] prog_addr = '0;
  logic [6:0] prog_data = '0;
  logic [3:0] acc_o, pc_o;
  logic [6:0] ir_o;
  logic [1:0] state_o;
  logic       carry_o, zero_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] img [16];
  logic [3:0] m_pc, m_acc;
  logic       m_cy;

  always #2.5 clk = ~clk;

  acc4_cpu dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .acc_o(acc_o), .pc_o(pc_o), .ir_o(ir_o),
    .state_o(state_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  function automatic logic [4:0] model(input logic [2:0] op, input logic [3:0] d,
                                       input logic [3:0] a);
    case (op)
      3'd0: return {1'b0, d};
      3'd1: return {1'b0, a} + {1'b0, d};
      3'd2: return {a < d, 4'(a - d)};
      3'd3: return {a == 4'hF, 4'(a + 4'd1)};
      3'd4: return {a == 4'h0, 4'(a - 4'd1)};
      3'd5: return {1'b0, a & d};
      3'd6: return {1'b0, a | d};
      default: return {1'b0, a ^ d};
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int a = 0; a < 16; a++) begin
      prog_we = 1'b1; prog_addr = 4'(a); prog_data = img[a];
      @(negedge clk);
    end
    prog_we = 1'b0;
    check("R1 pc", pc_o, 0);
    check("R1 ir", ir_o, 0);
    check("R1 acc", acc_o, 0);
    check("R1 carry", carry_o, 0);
    check("R1 state", state_o, 0);
    check("R9 zero after reset", zero_o, 1);
    rst = 1'b0;
    m_pc = '0; m_acc = '0; m_cy = 1'b0;
  endtask

  task automatic run_instr(input bit poke);
    logic [4:0] r;
    logic [6:0] w;
    step();
    w = img[m_pc];
    check("R2 decode", state_o, 1);
    check("R3 ir", ir_o, w);
    check("R3 pc", pc_o, 4'(m_pc + 4'd1));
    m_pc = 4'(m_pc + 4'd1);
    if (poke) begin
      prog_we = 1'b1; prog_addr = 4'(m_pc + 4'd2); prog_data = ~img[4'(m_pc + 4'd2)];
    end
    step();
    prog_we = 1'b0;
    check("R2 exec", state_o, 2);
    check("R4 acc held", acc_o, m_acc);
    step();
    r = model(w[6:4], w[3:0], m_acc);
    m_acc = r[3:0]; m_cy = r[4];
    check("R5 R6 R7 acc", acc_o, m_acc);
    check("R5 R6 R7 carry", carry_o, m_cy);
    check("R9 zero", zero_o, (m_acc == 0));
    check("R2 back to fetch", state_o, 0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // directed corners: R5 overflow/borrow, R7 wrap with nonzero immediates, R6 ops
    img[0]  = 7'b000_1111; img[1]  = 7'b011_0101; img[2]  = 7'b100_1010;
    img[3]  = 7'b001_0001; img[4]  = 7'b010_0001; img[5]  = 7'b101_1010;
    img[6]  = 7'b110_0101; img[7]  = 7'b111_1111; img[8]  = 7'b010_0000;
    img[9]  = 7'b100_1111; img[10] = 7'b011_1111; img[11] = 7'b001_1111;
    img[12] = 7'b010_1111; img[13] = 7'b000_0000; img[14] = 7'b011_0000;
    img[15] = 7'b100_0110;
    load_and_reset();
    // R8: writes while running are issued in the first pass and must not show on wrap
    for (int i = 0; i < 20; i++) run_instr(i < 12);
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 16; a++) img[a] = 7'($urandom);
      load_and_reset();
      for (int i = 0; i < 20; i++) run_instr(p[0] == 1'b1);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule